// File: doc/BRIEF.md
# Bit-Serial Parallel Multiply-Accumulate Unit

This block forms the sum of `PAIRS` products `W_i × A_i` by walking through the weight bits one position per cycle, while every multiplicand is handled at the same time. In each step, every multiplicand whose current weight bit is one is passed into an adder tree. The tree total goes through one shared barrel shifter, set to the current bit position, and the result is folded into an accumulator. The shift is done once on the tree output, not once per multiplicand.

Weights and multiplicands are both two's complement. Because the weight's top bit carries negative weight, the partial sum at the most significant position is subtracted rather than added. Driving the same values on both operand ports gives a sum of squares. This form suits an energy measure over a histogram block, alongside a dot product against a weight vector.

A one-cycle start pulse does four things: it captures both operand sets, clears the accumulator and the bit counter, and lowers the done flag. Exactly `WBITS` cycles later, done rises and the result is presented. The flag then stays high until the next start.

Top module: `bitserial_mac`

## Requirements
- R1: After reset, `done` is 0 and `sop` is 0.
- R2: On the clock edge that samples `start` high, the accumulator is cleared and `done` is lowered. In the cycle that follows, `sop` reads 0 and `done` reads 0.
- R3: `done` rises on the `WBITS`-th clock edge after the edge that sampled `start`. It then stays high, with `sop` unchanged, until the next start.
- R4: When `done` is high, `sop` equals the sum over all pairs of `W_i × A_i`. Both factors are taken as two's complement and the result is read as a two's-complement value `ABITS+WBITS+clog2(PAIRS)` bits wide. Pair `i` occupies element `i` of the packed operand arrays.
- R5: With `wIn` equal to `aIn` (and `WBITS` equal to `ABITS`), `sop` equals the sum of the squares of the operands.
- R6: The extreme operands are represented exactly with no wrap. When every weight and multiplicand is the most negative value, `sop` is `PAIRS × 2^(WBITS+ABITS-2)`. When weight is most negative and multiplicand most positive, the sum is the matching negative value.
- R7: Operand values present at the ports after the start cycle have no effect on the result of the operation in progress.
- R8: A start pulse that arrives while an operation is in progress abandons it. A fresh operation begins on the new operands, and `done` follows R3 counted from the new start.
- R9: All-zero weights give `sop` = 0 for any multiplicands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that captures operands and begins an operation |
| wIn | input | PAIRS×WBITS | Packed weight operands, element i is pair i, two's complement |
| aIn | input | PAIRS×ABITS | Packed multiplicand operands, element i is pair i, two's complement |
| done | output | 1 | High once the result is complete, until the next start |
| sop | output | ABITS+WBITS+clog2(PAIRS) | Sum of products, two's complement |

## Verification
The assertions assume that `start` is a synchronous pulse, so the control never sees a load and a shift step in the same cycle. They also assume that `PAIRS` is at least two and `WBITS` at least two, so that a most significant position exists to be subtracted. The stimulus raises `start` for single cycles in most cases. The restart case deliberately pulses `start` in the middle of a run. A behavioural model, driven by the same pins, predicts `done` and `sop` on every clock. Operands are scrambled after each capture, so any dependence on live port values shows up as a miscompare.

// File: rtl/bsmac_pkg.sv
package bsmac_pkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;   // capture operands, clear accumulator
    logic step;   // consume one weight bit
    logic neg;    // current bit is the sign position: subtract
  } macStrobe_t;

endpackage

// File: rtl/bsmac_ctrl.sv
module bsmac_ctrl
  import bsmac_pkg::*;
#(
  parameter int WBITS = 8,
  localparam int CW = (WBITS > 1) ? $clog2(WBITS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output macStrobe_t    strb,
  output logic [CW-1:0] bitPos,
  output logic          done
);

  localparam logic [CW-1:0] LASTPOS = CW'(WBITS - 1);

  logic busy;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
      done <= 1'b0;
    end else if (busy) begin
      if (cnt == LASTPOS) begin
        busy <= 1'b0;
        cnt  <= '0;
        done <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.load = start;
    strb.step = busy && !start;
    strb.neg  = (cnt == LASTPOS);
    bitPos    = cnt;
  end

  AST_START_LOWERS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done); // R2

endmodule

// File: rtl/bsmac_dp.sv
module bsmac_dp
  import bsmac_pkg::*;
#(
  parameter int PAIRS = 36,
  parameter int WBITS = 8,
  parameter int ABITS = 8,
  localparam int CW   = (WBITS > 1) ? $clog2(WBITS) : 1,
  localparam int LOGP = $clog2(PAIRS),
  localparam int SUMW = ABITS + LOGP,
  localparam int OUTW = ABITS + WBITS + LOGP,
  localparam int PAD  = 1 << LOGP,
  localparam int NODES = 2 * PAD - 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  macStrobe_t                    strb,
  input  logic [CW-1:0]                 bitPos,
  input  logic [PAIRS-1:0][WBITS-1:0]   wIn,
  input  logic [PAIRS-1:0][ABITS-1:0]   aIn,
  output logic [OUTW-1:0]               sop
);

  logic [PAIRS-1:0][WBITS-1:0] wShift;
  logic [PAIRS-1:0][ABITS-1:0] aHold;
  logic [NODES-1:0][SUMW-1:0]  node;
  logic [OUTW-1:0]             treeExt;
  logic [OUTW-1:0]             shifted;
  logic [OUTW-1:0]             acc;

  // Per-pair operand registers and gated leaves.
  for (genvar i = 0; i < PAIRS; i++) begin : g_pair
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wShift[i] <= '0;
        aHold[i]  <= '0;
      end else if (strb.load) begin
        wShift[i] <= wIn[i];
        aHold[i]  <= aIn[i];
      end else if (strb.step) begin
        wShift[i] <= {1'b0, wShift[i][WBITS-1:1]};
      end
    end

    assign node[PAD-1+i] = wShift[i][0]
                         ? {{LOGP{aHold[i][ABITS-1]}}, aHold[i]}
                         : '0;
  end

  // Unused leaves of the padded tree.
  for (genvar j = PAIRS; j < PAD; j++) begin : g_padLeaf
    assign node[PAD-1+j] = '0;
  end

  // Binary adder tree, node k sums its two children.
  for (genvar k = 0; k < PAD - 1; k++) begin : g_tree
    assign node[k] = node[2*k+1] + node[2*k+2];
  end

  // One shared shifter applied to the tree total.
  always_comb begin
    treeExt = {{(OUTW-SUMW){node[0][SUMW-1]}}, node[0]};
    shifted = treeExt << bitPos;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (strb.load) begin
      acc <= '0;
    end else if (strb.step) begin
      acc <= strb.neg ? (acc - shifted) : (acc + shifted);
    end
  end

  assign sop = acc;

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.load, strb.step})); // R8

  AST_LOAD_CLEARS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load |=> (sop == '0)); // R2

endmodule

// File: rtl/bitserial_mac.sv
module bitserial_mac
  import bsmac_pkg::*;
#(
  parameter int PAIRS = 36,
  parameter int WBITS = 8,
  parameter int ABITS = 8,
  localparam int CW   = (WBITS > 1) ? $clog2(WBITS) : 1,
  localparam int OUTW = ABITS + WBITS + $clog2(PAIRS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [PAIRS-1:0][WBITS-1:0] wIn,
  input  logic [PAIRS-1:0][ABITS-1:0] aIn,
  output logic                        done,
  output logic [OUTW-1:0]             sop
);

  macStrobe_t    strb;
  logic [CW-1:0] bitPos;

  bsmac_ctrl #(.WBITS(WBITS)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .strb   (strb),
    .bitPos (bitPos),
    .done   (done)
  );

  bsmac_dp #(.PAIRS(PAIRS), .WBITS(WBITS), .ABITS(ABITS)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strb),
    .bitPos (bitPos),
    .wIn    (wIn),
    .aIn    (aIn),
    .sop    (sop)
  );

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R3

  AST_SOP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(sop)); // R3

  AST_IDLE_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !strb.step); // R3

endmodule

// File: tb/bitserial_mac_test.sv
module bitserial_mac_test;

  localparam int P = 36;
  localparam int N = 8;
  localparam int M = 8;
  localparam int OW = M + N + $clog2(P);

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [P-1:0][N-1:0] wIn;
  logic [P-1:0][M-1:0] aIn;
  logic done;
  logic [OW-1:0] sop;

  int checks = 0;
  int fails = 0;
  string curTag = "R4";
  bit finished = 0;

  always #5 clk = ~clk;

  bitserial_mac #(.PAIRS(P), .WBITS(N), .ABITS(M)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .wIn(wIn), .aIn(aIn), .done(done), .sop(sop)
  );

  function automatic int refSum(input logic [P-1:0][N-1:0] w,
                                input logic [P-1:0][M-1:0] a);
    int s = 0;
    for (int i = 0; i < P; i++) s += int'($signed(w[i])) * int'($signed(a[i]));
    return s;
  endfunction

  // Behavioural reference, advanced on the same edges as the design.
  int expSop;
  int left;
  bit expDone;
  bit expZero;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expSop <= 0; left <= 0; expDone <= 0; expZero <= 1;
    end else if (start) begin
      expSop <= refSum(wIn, aIn); left <= N; expDone <= 0; expZero <= 1;
    end else begin
      expZero <= 0;
      if (left > 0) begin
        left <= left - 1;
        if (left == 1) expDone <= 1;
      end
    end
  end

  // Compared on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !finished) begin
      checks++;
      if (done !== expDone) begin
        fails++;
        $display("FAIL R3 done: actual %0b expected %0b", done, expDone);
      end
      if (expZero) begin
        checks++;
        if (sop !== '0) begin
          fails++;
          $display("FAIL R2 sop after clear: actual %0d expected 0", $signed(sop));
        end
      end else if (expDone) begin
        checks++;
        if (int'($signed(sop)) != expSop) begin
          fails++;
          $display("FAIL %s sop: actual %0d expected %0d", curTag, $signed(sop), expSop);
        end
      end
    end
  end

  task automatic pulse(input logic [P-1:0][N-1:0] w, input logic [P-1:0][M-1:0] a);
    @(negedge clk); #2;
    wIn = w; aIn = a; start = 1'b1;
    @(negedge clk); #2;
    start = 1'b0;
  endtask

  task automatic scramble(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      for (int i = 0; i < P; i++) begin
        wIn[i] = N'($urandom);
        aIn[i] = M'($urandom);
      end
      @(negedge clk); #2;
    end
  endtask

  task automatic runOp(input string tag, input logic [P-1:0][N-1:0] w,
                       input logic [P-1:0][M-1:0] a);
    curTag = tag;
    pulse(w, a);
    scramble(N + 4);
  endtask

  logic [P-1:0][N-1:0] tw;
  logic [P-1:0][M-1:0] ta;

  initial begin
    rst_n = 1'b0; start = 1'b0; wIn = '0; aIn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    rst_n = 1'b1;
    @(negedge clk); #1;
    checks++;
    if (done !== 1'b0 || sop !== '0) begin
      fails++;
      $display("FAIL R1 reset: actual done %0b sop %0d expected 0 0", done, sop);
    end

    // R4: random operand patterns.
    for (int t = 0; t < 6; t++) begin
      for (int i = 0; i < P; i++) begin tw[i] = N'($urandom); ta[i] = M'($urandom); end
      runOp("R4", tw, ta);
    end
    // R4: alternating signs, sparse weights.
    for (int i = 0; i < P; i++) begin
      tw[i] = (i % 3 == 0) ? N'(-1) : N'(i);
      ta[i] = (i % 2 == 0) ? M'(-i) : M'(100);
    end
    runOp("R4", tw, ta);

    // R5: sum of squares.
    for (int t = 0; t < 3; t++) begin
      for (int i = 0; i < P; i++) begin tw[i] = N'($urandom); ta[i] = tw[i]; end
      runOp("R5", tw, ta);
    end

    // R6: extreme magnitudes.
    for (int i = 0; i < P; i++) begin tw[i] = 8'h80; ta[i] = 8'h80; end
    runOp("R6", tw, ta);
    for (int i = 0; i < P; i++) begin tw[i] = 8'h80; ta[i] = 8'h7f; end
    runOp("R6", tw, ta);
    for (int i = 0; i < P; i++) begin tw[i] = 8'h7f; ta[i] = 8'h80; end
    runOp("R6", tw, ta);

    // R9: zero weights.
    for (int i = 0; i < P; i++) begin tw[i] = '0; ta[i] = M'($urandom); end
    runOp("R9", tw, ta);

    // R7: ports scrambled every cycle after capture (runOp does it);
    // here also a second, different pattern held on the ports.
    for (int i = 0; i < P; i++) begin tw[i] = N'(i + 1); ta[i] = M'(3); end
    curTag = "R7";
    pulse(tw, ta);
    wIn = '1; aIn = '1;
    repeat (N + 4) @(negedge clk);
    #2;

    // R8: restart in the middle of a run.
    for (int i = 0; i < P; i++) begin tw[i] = N'($urandom); ta[i] = M'($urandom); end
    curTag = "R8";
    pulse(tw, ta);
    scramble(3);
    for (int i = 0; i < P; i++) begin tw[i] = N'($urandom); ta[i] = M'($urandom); end
    pulse(tw, ta);
    scramble(N + 6);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule